// File: doc/BRIEF.md
# Queued SPI Master Controller

This block is a serial peripheral interface master that works through a queue of up to 32 transfers held in local storage, with no processor help once it has started. Each queue entry has three words: the word to send, the word received, and a command word. The command word gives the chip-select value, the transfer length and a continue flag. A host port reaches the three storage areas and a small set of control registers. Among these are the start, end and current queue pointers, the clock divider and a wrap enable.

Once started, the controller fetches the entry under the current pointer and shifts it out in SPI mode 0, most significant bit first. It stores the received bits back into the same entry, then waits a fixed 17 clocks before fetching the next entry. Separate start and end pointers let software split the queue into segments. With wrap enabled, the controller loops over its segment without end and overwrites old receive words with new ones. With wrap disabled, it stops after the end entry and raises a completion flag.

Top module: `qspi_queue_ctrl`

## Requirements
- R1: After reset, sck_o is 0, cs_o is 4'hF, irq_o is 0, and the status, pointer and control registers all read 0.
- R2: A transfer of n bits drives mosi_o with bits n-1 down to 0 of the entry's transmit word, each valid before its rising SCK edge. miso_i is sampled on each rising edge. The n received bits, right-aligned with zeros above them, are written to the same entry's receive word.
- R3: The length field is command bits [4:0]. Values 8 to 16 give that many bits; any other value gives 16 bits.
- R4: During an entry's transfer, cs_o equals command bits [8:5]. cs_o is 4'hF while idle and in the gap after an entry whose continue bit is 0.
- R5: When command bit [9] (continue) is 1, cs_o keeps that entry's value through the following gap, so chained entries form one unbroken select.
- R6: Each SCK half period is div+1 clocks, where div is divider register bits [7:0]. The first rising edge of an entry comes exactly 17+div+1 clocks after the last falling edge of the previous entry.
- R7: Entries run from the start pointer, and the pointer steps by one modulo 32. With wrap off, the run stops after the end entry: the done flag is set, busy clears, and the current pointer reads back as the start pointer.
- R8: With wrap on, the entry after the end entry is the start entry and the run continues. Later passes overwrite the receive words. Clearing wrap while a run is active makes it stop after the next end entry.
- R9: A host write to the current pointer takes effect at the next entry fetch. The entry in flight finishes unchanged.
- R10: The done flag is cleared by writing 1 to status bit [1]. irq_o equals done flag AND the interrupt enable.
- R11: Host writes to transmit or command words are accepted during a run. The entry in flight uses the values latched when it was fetched.
- R12: Host map (7-bit address): transmit words at 0x00+e, receive words (read-only) at 0x20+e, command words at 0x40+e. Register 0x60 is control: bit0 go (write 1 when idle), bit1 wrap, bit2 irq enable. Register 0x61 holds the start pointer in [4:0] and the end pointer in [12:8]. Register 0x62 is the current pointer, 0x63 the divider, and 0x64 the status: [0] busy, [1] done, [12:8] current pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_we_i | input | 1 | Host write strobe |
| host_addr_i | input | 7 | Host word address |
| host_wdata_i | input | 16 | Host write data |
| host_rdata_o | output | 16 | Host read data (combinational from address) |
| sck_o | output | 1 | Serial clock, idle low |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_o | output | 4 | Chip-select value from the active command |
| irq_o | output | 1 | Queue-finished interrupt request |

## Verification
A wrong sequencer state shows at the pins within one entry. A pointer that skips or repeats an entry sends the wrong transmit bits and the wrong select value on the very next fetch. A bad gap counter moves the next entry's first rising edge away from the fixed 17+div+1 clock distance. A wrong continue decision shows as extra or missing select-release cycles inside a chained run. A misplaced receive write only appears when the host reads the receive area after the run, so every run ends by reading back each entry that was touched and checking that the neighbouring entries are unchanged.

// File: rtl/qspi_pkg.sv
package qspi_pkg;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_XFER, SEQ_GAP} seq_e;

  // command word: [9] continue, [8:5] select value, [4:0] length
  localparam int CMD_W = 10;
  typedef struct packed {
    logic       cont;
    logic [3:0] cs;
    logic [4:0] nbits;
  } cmd_t;

  function automatic logic [4:0] eff_bits(input logic [4:0] f);
    return (f < 5'd8 || f > 5'd16) ? 5'd16 : f;
  endfunction
endpackage

// File: rtl/qspi_mem.sv
module qspi_mem #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 16,
  parameter int NRD   = 1,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [AW-1:0]               waddr_i,
  input  logic [WIDTH-1:0]            wdata_i,
  input  logic [NRD-1:0][AW-1:0]      raddr_i,
  output logic [NRD-1:0][WIDTH-1:0]   rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata_o[g] = mem_q[raddr_i[g]];
  end
endmodule

// File: rtl/qspi_shift.sv
module qspi_shift #(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 8,
  parameter int CNT_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] tx_i,
  input  logic [CNT_W-1:0]  nbits_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              miso_i,
  output logic              sck_o,
  output logic              mosi_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_o
);
  logic              busy_q, sck_q;
  logic [DIV_W-1:0]  hcnt_q;
  logic [CNT_W-1:0]  bcnt_q;
  logic [DATA_W-1:0] sh_q, rx_q;
  logic              edge_now;

  assign edge_now = busy_q && (hcnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      hcnt_q <= '0;
      bcnt_q <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      sck_q  <= 1'b0;
      hcnt_q <= '0;
      bcnt_q <= nbits_i;
      sh_q   <= tx_i << (DATA_W - int'(nbits_i));
      rx_q   <= '0;
    end else if (edge_now) begin
      hcnt_q <= '0;
      if (!sck_q) begin
        sck_q <= 1'b1;
        rx_q  <= {rx_q[DATA_W-2:0], miso_i};
      end else begin
        sck_q  <= 1'b0;
        sh_q   <= sh_q << 1;
        bcnt_q <= bcnt_q - CNT_W'(1);
        if (bcnt_q == CNT_W'(1)) busy_q <= 1'b0;
      end
    end else if (busy_q) begin
      hcnt_q <= hcnt_q + DIV_W'(1);
    end
  end

  assign sck_o  = sck_q;
  assign mosi_o = sh_q[DATA_W-1];
  assign busy_o = busy_q;
  assign rx_o   = rx_q;
  assign done_o = edge_now && sck_q && (bcnt_q == CNT_W'(1));

  // R2
  fall_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!sck_q && !busy_q));
endmodule

// File: rtl/qspi_queue_ctrl.sv
module qspi_queue_ctrl
  import qspi_pkg::*;
#(
  parameter  int N_ENTRIES = 32,
  parameter  int DATA_W    = 16,
  parameter  int DIV_W     = 8,
  parameter  int GAP_CLKS  = 17,
  localparam int PTR_W     = $clog2(N_ENTRIES),
  localparam int ADDR_W    = PTR_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_we_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [3:0]        cs_o,
  output logic              irq_o
);
  localparam int GCNT_W = $clog2(GAP_CLKS);

  seq_e              state_q;
  logic [GCNT_W-1:0] gcnt_q;
  logic [PTR_W-1:0]  start_q, end_q, cur_q, ent_q, fetch_ptr;
  logic [DIV_W-1:0]  div_q;
  logic              wrap_q, irq_en_q, done_q, last_q, cont_q;
  logic [3:0]        cs_q;
  logic [1:0]        region;
  logic [2:0]        reg_sel;
  logic              reg_we, go_wr, cur_wr, fetch;
  logic              sh_busy, sh_done;
  logic [DATA_W-1:0] sh_rx;
  logic [1:0][DATA_W-1:0] tx_rd;
  logic [1:0][CMD_W-1:0]  cmd_rd;
  logic [0:0][DATA_W-1:0] rx_rd;
  cmd_t              fcmd;

  assign region  = host_addr_i[ADDR_W-1 -: 2];
  assign reg_sel = host_addr_i[2:0];
  assign reg_we  = host_we_i && (region == 2'd3);
  assign go_wr   = reg_we && (reg_sel == 3'd0) && host_wdata_i[0];
  assign cur_wr  = reg_we && (reg_sel == 3'd2);

  assign fetch_ptr = (state_q == SEQ_IDLE) ? start_q : cur_q;
  assign fetch = ((state_q == SEQ_IDLE) && go_wr) ||
                 ((state_q == SEQ_GAP) && (gcnt_q == GCNT_W'(GAP_CLKS - 1)));
  assign fcmd = cmd_t'(cmd_rd[0]);

  qspi_mem #(.DEPTH(N_ENTRIES), .WIDTH(DATA_W), .NRD(2)) u_tx_mem (
    .clk_i, .rst_ni,
    .we_i   (host_we_i && (region == 2'd0)),
    .waddr_i(host_addr_i[PTR_W-1:0]),
    .wdata_i(host_wdata_i),
    .raddr_i({host_addr_i[PTR_W-1:0], fetch_ptr}),
    .rdata_o(tx_rd)
  );

  qspi_mem #(.DEPTH(N_ENTRIES), .WIDTH(CMD_W), .NRD(2)) u_cmd_mem (
    .clk_i, .rst_ni,
    .we_i   (host_we_i && (region == 2'd2)),
    .waddr_i(host_addr_i[PTR_W-1:0]),
    .wdata_i(host_wdata_i[CMD_W-1:0]),
    .raddr_i({host_addr_i[PTR_W-1:0], fetch_ptr}),
    .rdata_o(cmd_rd)
  );

  qspi_mem #(.DEPTH(N_ENTRIES), .WIDTH(DATA_W), .NRD(1)) u_rx_mem (
    .clk_i, .rst_ni,
    .we_i   (sh_done),
    .waddr_i(ent_q),
    .wdata_i(sh_rx),
    .raddr_i(host_addr_i[PTR_W-1:0]),
    .rdata_o(rx_rd)
  );

  qspi_shift #(.DATA_W(DATA_W), .DIV_W(DIV_W), .CNT_W(5)) u_shift (
    .clk_i, .rst_ni,
    .start_i(fetch),
    .tx_i   (tx_rd[0]),
    .nbits_i(eff_bits(fcmd.nbits)),
    .div_i  (div_q),
    .miso_i,
    .sck_o,
    .mosi_o,
    .busy_o (sh_busy),
    .done_o (sh_done),
    .rx_o   (sh_rx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      gcnt_q  <= '0;
      start_q <= '0;
      end_q   <= '0;
      cur_q   <= '0;
      ent_q   <= '0;
      div_q   <= '0;
      wrap_q  <= 1'b0;
      irq_en_q <= 1'b0;
      done_q  <= 1'b0;
      last_q  <= 1'b0;
      cont_q  <= 1'b0;
      cs_q    <= '1;
    end else begin
      if (reg_we) begin
        case (reg_sel)
          3'd0: begin
            wrap_q   <= host_wdata_i[1];
            irq_en_q <= host_wdata_i[2];
          end
          3'd1: begin
            start_q <= host_wdata_i[PTR_W-1:0];
            end_q   <= host_wdata_i[8 +: PTR_W];
          end
          3'd3: div_q <= host_wdata_i[DIV_W-1:0];
          3'd4: if (host_wdata_i[1]) done_q <= 1'b0;
          default: ;
        endcase
      end

      case (state_q)
        SEQ_IDLE: ;
        SEQ_XFER: if (sh_done) begin
          if (last_q && !wrap_q) begin
            state_q <= SEQ_IDLE;
            cs_q    <= '1;
            done_q  <= 1'b1;
          end else begin
            state_q <= SEQ_GAP;
            gcnt_q  <= '0;
            if (!cont_q) cs_q <= '1;
          end
        end
        SEQ_GAP: gcnt_q <= gcnt_q + GCNT_W'(1);
        default: state_q <= SEQ_IDLE;
      endcase

      if (fetch) begin
        state_q <= SEQ_XFER;
        ent_q   <= fetch_ptr;
        last_q  <= (fetch_ptr == end_q);
        cont_q  <= fcmd.cont;
        cs_q    <= fcmd.cs;
        cur_q   <= (fetch_ptr == end_q) ? start_q : fetch_ptr + PTR_W'(1);
      end
      // host pointer write wins; used at the next fetch
      if (cur_wr) cur_q <= host_wdata_i[PTR_W-1:0];
    end
  end

  assign cs_o  = cs_q;
  assign irq_o = done_q && irq_en_q;

  always_comb begin
    host_rdata_o = '0;
    case (region)
      2'd0: host_rdata_o = tx_rd[1];
      2'd1: host_rdata_o = rx_rd[0];
      2'd2: host_rdata_o[CMD_W-1:0] = cmd_rd[1];
      default: case (reg_sel)
        3'd0: host_rdata_o[2:0] = {irq_en_q, wrap_q, 1'b0};
        3'd1: begin
          host_rdata_o[PTR_W-1:0]  = start_q;
          host_rdata_o[8 +: PTR_W] = end_q;
        end
        3'd2: host_rdata_o[PTR_W-1:0] = cur_q;
        3'd3: host_rdata_o[DIV_W-1:0] = div_q;
        3'd4: begin
          host_rdata_o[1:0]        = {done_q, state_q != SEQ_IDLE};
          host_rdata_o[8 +: PTR_W] = cur_q;
        end
        default: ;
      endcase
    endcase
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_IDLE) |-> (!sck_o && cs_o == 4'hF));
  // R6
  gap_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_GAP) |-> (!sck_o && !sh_busy));
  // R5
  cont_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_GAP && $past(state_q) == SEQ_GAP && cont_q) |-> $stable(cs_o));
  // R7
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> (state_q == SEQ_IDLE && $past(state_q) == SEQ_XFER));
  // R2
  xfer_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_XFER) |-> (sh_busy || sh_done || $past(fetch)));
endmodule

// File: tb/qspi_queue_ctrl_tb.sv
module qspi_queue_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        h_we = 1'b0;
  logic [6:0]  h_addr = '0;
  logic [15:0] h_wd = '0, h_rd;
  logic        sck, mosi, miso, irq;
  logic [3:0]  cs;
  logic        inv = 1'b0;

  assign miso = mosi ^ inv;

  qspi_queue_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .host_we_i(h_we), .host_addr_i(h_addr), .host_wdata_i(h_wd), .host_rdata_o(h_rd),
    .sck_o(sck), .mosi_o(mosi), .miso_i(miso), .cs_o(cs), .irq_o(irq)
  );

  int checks = 0, fails = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [15:0] exp_tx [32];
  logic [4:0]  exp_nf [32];
  logic [3:0]  exp_cs [32];
  logic        exp_ct [32];
  int          seq_a [64];

  logic        log_mosi [4096];
  logic [3:0]  log_cs [4096];
  int          rise_c [4096], fall_c [4096];
  int          rise_n = 0, fall_n = 0, cs_hi = 0, exp_total = 0;
  logic        sck_d = 1'b0;

  always @(negedge clk) begin
    if (sck && !sck_d && rise_n < 4096) begin
      log_mosi[rise_n] = mosi; log_cs[rise_n] = cs; rise_c[rise_n] = cyc; rise_n++;
    end
    if (!sck && sck_d && fall_n < 4096) begin
      fall_c[fall_n] = cyc; fall_n++;
    end
    if (rise_n > 0 && fall_n < exp_total && cs == 4'hF) cs_hi++;
    sck_d = sck;
  end

  always @(posedge clk) if (cyc > 150000) begin
    fails++;
    $display("FAIL watchdog act=%0d exp=<150000", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk); h_we = 1'b1; h_addr = a[6:0]; h_wd = d;
    @(negedge clk); h_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    @(negedge clk); h_addr = a[6:0]; #1; d = h_rd;
  endtask

  function automatic int eff(input logic [4:0] f);
    return (f < 8 || f > 16) ? 16 : int'(f);
  endfunction

  task automatic load(input int e, input logic [15:0] tx, input logic [4:0] nf,
                      input logic [3:0] c, input logic ct);
    exp_tx[e] = tx; exp_nf[e] = nf; exp_cs[e] = c; exp_ct[e] = ct;
    wr(e, tx);
    wr(64 + e, {6'b0, ct, c, nf});
  endtask

  task automatic run(input int st, input int en, input logic wrap, input logic ie,
                     input int dv, input int len);
    exp_total = 0;
    for (int i = 0; i < len; i++) exp_total += eff(exp_nf[seq_a[i]]);
    wr(8'h61, {3'b0, en[4:0], 3'b0, st[4:0]});
    wr(8'h63, 16'(dv));
    rise_n = 0; fall_n = 0; cs_hi = 0;
    wr(8'h60, {13'b0, ie, wrap, 1'b1});
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    rd(8'h64, s);
    while (s[0]) rd(8'h64, s);
  endtask

  // walks the pin log for entries seq_a[0..len-1]
  task automatic verify(input int len, input int dv, input string tag);
    int k = 0;
    for (int i = 0; i < len; i++) begin
      int e = seq_a[i];
      int n = eff(exp_nf[e]);
      logic ok = 1'b1;
      for (int b = n - 1; b >= 0; b--) begin
        if (b == n - 1 && i > 0)
          chk({tag, " R6 gap"}, rise_c[k] - fall_c[k-1], 18 + dv);
        if (log_mosi[k] !== exp_tx[e][b] || log_cs[k] !== exp_cs[e]) ok = 1'b0;
        k++;
      end
      chk({tag, " R2/R3/R4 bits+cs entry"}, {ok, 8'(e)}, {1'b1, 8'(e)});
    end
    chk({tag, " R6 half period"}, rise_c[1] - rise_c[0], 2 * (dv + 1));
  endtask

  task automatic chk_rx(input int e, input logic iv, input string tag);
    logic [15:0] d, m;
    int n = eff(exp_nf[e]);
    m = 16'((32'd1 << n) - 1);
    rd(32 + e, d);
    chk({tag, " R2 rx word"}, d, (exp_tx[e] ^ {16{iv}}) & m);
  endtask

  initial begin
    logic [15:0] d;
    logic [15:0] new2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    chk("R1 sck", sck, 0);
    chk("R1 cs", cs, 4'hF);
    chk("R1 irq", irq, 0);
    rd(8'h64, d); chk("R1 status", d, 0);
    rd(8'h61, d); chk("R1 pointers", d, 0);
    rd(8'h60, d); chk("R1 control", d, 0);

    // T1: entries 0..7, lengths 8..15, div 1, irq enabled
    for (int i = 0; i < 8; i++) begin
      load(i, 16'(32'hA5C3 ^ (i * 32'h1111)), 5'(8 + i), 4'(i), 1'b0);
      seq_a[i] = i;
    end
    rd(64 + 3, d); chk("R12 cmd readback", d, {6'b0, 1'b0, 4'd3, 5'd11});
    inv = 1'b0;
    run(0, 7, 1'b0, 1'b1, 1, 8);
    rd(8'h60, d); chk("R12 control readback", d, 16'h4);
    wait_idle();
    verify(8, 1, "T1");
    for (int i = 0; i < 8; i++) chk_rx(i, 1'b0, "T1");
    chk("R4 cs gaps released", cs_hi, 17 * 7);
    rd(8'h64, d); chk("R7 done, cur=start", d, 16'h0002);
    chk("R10 irq set", irq, 1);
    wr(8'h64, 16'h0002);
    rd(8'h64, d); chk("R10 done cleared", d[1], 0);
    chk("R10 irq cleared", irq, 0);

    // T2: all 32 entries, length field sweeps 0..31, inverted miso, irq off
    for (int i = 0; i < 32; i++) begin
      load(i, 16'((i * 32'h9E37) ^ 32'h5A5A), 5'(i), 4'(i), 1'b0);
      seq_a[i] = i;
    end
    inv = 1'b1;
    run(0, 31, 1'b0, 1'b0, 0, 32);
    wait_idle();
    verify(32, 0, "T2");
    chk("R3 total bits", rise_n, exp_total);
    for (int i = 0; i < 32; i++) chk_rx(i, 1'b1, "T2");
    rd(8'h64, d); chk("R10 done without irq", d[1], 1);
    chk("R10 irq masked", irq, 0);
    wr(8'h64, 16'h0002);

    // T3: segment 20..23, all continue, div 3
    for (int i = 0; i < 4; i++) begin
      load(20 + i, 16'(32'hC0DE + i * 32'h0F0F), 5'd16, 4'h9, 1'b1);
      seq_a[i] = 20 + i;
    end
    inv = 1'b0;
    run(20, 23, 1'b0, 1'b0, 3, 4);
    wait_idle();
    verify(4, 3, "T3");
    chk("R5 unbroken select", cs_hi, 0);
    chk("R5 stream length", rise_n, 64);
    for (int i = 20; i < 24; i++) chk_rx(i, 1'b0, "T3");
    chk_rx(19, 1'b1, "T3 R7 outside segment");
    chk_rx(24, 1'b1, "T3 R7 outside segment");
    rd(8'h62, d); chk("R7 cur=start", d, 20);
    wr(8'h64, 16'h0002);

    // T4: mixed continue bits on entries 4..7
    for (int i = 0; i < 4; i++) begin
      load(4 + i, 16'(32'h1234 * (i + 3)), 5'd9, 4'(4 + i), (i % 2) == 0);
      seq_a[i] = 4 + i;
    end
    run(4, 7, 1'b0, 1'b0, 0, 4);
    wait_idle();
    verify(4, 0, "T4");
    chk("R4/R5 mixed release count", cs_hi, 17);
    wr(8'h64, 16'h0002);

    // T5: pointer rewrite while entry 0 is in flight
    for (int i = 0; i < 8; i++) load(i, 16'(32'h3C00 + i * 32'h0101), 5'd16, 4'(i), 1'b0);
    seq_a[0] = 0; seq_a[1] = 5; seq_a[2] = 6; seq_a[3] = 7;
    run(0, 7, 1'b0, 1'b0, 0, 4);
    while (rise_n < 2) @(negedge clk);
    wr(8'h62, 16'd5);
    wait_idle();
    verify(4, 0, "T5 R9");
    chk("R9 entry count", rise_n, 64);
    wr(8'h64, 16'h0002);

    // T6: wrap over 2..3, transmit rewrite during flight, then stop
    load(2, 16'h00A7, 5'd8, 4'h2, 1'b0);
    load(3, 16'h005E, 5'd8, 4'h3, 1'b0);
    seq_a[0] = 2; seq_a[1] = 3;
    new2 = 16'h00C9;
    run(2, 3, 1'b1, 1'b1, 0, 2);
    exp_total = 100000;
    while (rise_n < 1) @(negedge clk);
    wr(2, new2);
    while (rise_n < 40) @(negedge clk);
    chk("R8 still busy with wrap", irq, 0);
    wr(8'h60, 16'h0004);
    wait_idle();
    verify(2, 0, "T6 R11 in-flight kept");
    begin
      logic ok = 1'b1;
      for (int b = 7; b >= 0; b--) if (log_mosi[16 + 7 - b] !== new2[b]) ok = 1'b0;
      chk("R8 third entry is start with new data", ok, 1);
    end
    chk("R8 whole passes", rise_n % 16, 0);
    chk("R8 wrapped more than once", rise_n > 32, 1);
    exp_tx[2] = new2;
    chk_rx(2, 1'b0, "T6 R8/R11 overwrite");
    chk_rx(3, 1'b0, "T6 R8");
    rd(8'h64, d); chk("R7 stop status", d, {3'b0, 5'd2, 6'b0, 2'b10});
    chk("R10 irq after wrap stop", irq, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule